// File: doc/BRIEF.md
# Prescaled Free-Running Interval Timer

This block is an 8-bit up-counter that never stops while its clock runs. A power-of-two prescaler with eight selectable ratios (divide by 8 up to divide by 1024) paces the counter. Each time the count rolls over from 0xFF to 0x00 the block latches an interrupt request. It also emits a single-cycle tick meant for a watchdog further downstream.

Software reaches the block through one byte-wide location. A read of that location always returns the live count. A write to the same location lands in a control byte that holds three fields:

- the ratio select;
- a counter-clear bit that drops back to zero on its own;
- three mode flags. These are stored and driven out as levels, and this block does not act on them.

A clear restarts the prescaler as well as the counter. The first step after a clear therefore comes one full divide period later.

Top module: `tick_interval_timer`

## Requirements
- R1: After a synchronous reset the count reads 0x00, the interrupt request and the watchdog tick are low, and the mode outputs are wake=0, rc-watchdog=0, watchdog=1.
- R2: Out of reset the ratio select is 3'b111 (divide by 1024). The count first reads 1 exactly 1024 clocks after reset is released.
- R3: With ratio select value s (control bits 2:0), the count advances once every 8·2^s clocks.
- R4: Reads always return the count. A write whose bit 3 is 0 changes only the control byte and leaves the count untouched.
- R5: Writing a byte with bit 3 set clears the count and the prescaler one clock after the write. The bit then falls back to 0 by itself, so counting resumes, and the first increment comes one full divide period after the clear.
- R6: When the count rolls over from 0xFF to 0x00, the interrupt request goes high on the same clock edge.
- R7: The interrupt request stays high until a one-cycle acknowledge clears it.
- R8: If an acknowledge and a rollover fall on the same edge, the interrupt request stays high.
- R9: Each rollover produces a watchdog tick that is high for exactly one clock.
- R10: Control bits 6, 5 and 4 are driven out as wake, rc-watchdog and watchdog level outputs.
- R11: A change of ratio select without bit 3 set takes effect at the next prescaler comparison and does not reset the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the shared location (loads the control byte) |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Live count, returned on reads of the shared location |
| irq_ack | input | 1 | One-cycle acknowledge that clears the interrupt request |
| irq_req | output | 1 | Latched rollover interrupt request |
| wdt_tick | output | 1 | One-cycle pulse on every rollover |
| mode_wake | output | 1 | Stored wake mode flag (control bit 6) |
| mode_rcwd | output | 1 | Stored rc-watchdog mode flag (control bit 5) |
| mode_wdog | output | 1 | Stored watchdog mode flag (control bit 4) |

## Verification
The embedded properties check, on every cycle, the following:

- the count only ever steps by one or returns to zero;
- a rollover raises the request and the tick;
- the request holds until it is acknowledged, and an acknowledge loses to a simultaneous rollover;
- the clear bit drops back by itself;
- no prescaler tick arrives straight after a restart.

The exact period for each of the eight ratios, the 1024-clock first step out of reset, and the point at which a changed ratio takes hold can only be shown by the bench's timed scenarios. The same holds for the count surviving a write with the clear bit at 0, and for the mode levels following the written byte.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int CNT_W    = 8;
    localparam int SEL_W    = 3;
    localparam int MIN_LOG2 = 3;
    localparam int NUM_TAPS = 1 << SEL_W;
    localparam int CHAIN_W  = MIN_LOG2 + NUM_TAPS - 1;

    typedef struct packed {
        logic             spare;
        logic             wake_en;
        logic             rc_wd_en;
        logic             wd_en;
        logic             clr;
        logic [SEL_W-1:0] rate;
    } ctl_t;

    localparam ctl_t CTL_RST = '{spare: 1'b0, wake_en: 1'b0, rc_wd_en: 1'b0,
                                 wd_en: 1'b1, clr: 1'b0, rate: '1};

    function automatic ctl_t ctl_from_byte(input logic [7:0] b);
        ctl_t c;
        c       = ctl_t'(b);
        c.spare = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
    import itmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctl_t       ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RST;
        end else if (wr_en) begin
            ctl <= ctl_from_byte(wr_data);
        end else begin
            ctl.clr <= 1'b0;
        end
    end

    AST_CLR_SELF_DROP: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr && !(wr_en && wr_data[3])) |=> !ctl.clr); // R5

endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
    import itmr_pkg::*;
#(
    parameter int P_MIN_LOG2 = MIN_LOG2,
    parameter int P_SEL_W    = SEL_W
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [P_SEL_W-1:0] rate,
    output logic               tick
);

    localparam int TAPS = 1 << P_SEL_W;
    localparam int CW   = P_MIN_LOG2 + TAPS - 1;

    logic [CW-1:0]   chain;
    logic [TAPS-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            chain <= '0;
        end else begin
            chain <= chain + 1'b1;
        end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign taps[i] = &chain[P_MIN_LOG2+i-1:0];
    end

    assign tick = taps[rate];

    AST_NO_TICK_AFTER_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick); // R5

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int P_CNT_W = CNT_W
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               tick,
    input  logic               ack,
    output logic [P_CNT_W-1:0] count,
    output logic               irq,
    output logic               ovf_pulse
);

    logic wrap;

    assign wrap = tick && !clear && (count == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            irq       <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            if (clear) begin
                count <= '0;
            end else if (tick) begin
                count <= count + 1'b1;
            end
            irq       <= wrap || (irq && !ack);
            ovf_pulse <= wrap;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(count) |-> (count == P_CNT_W'($past(count) + 1'b1)) || (count == '0)); // R3
    AST_WRAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (tick && !clear && count == '1) |=> (irq && ovf_pulse && count == '0)); // R6
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq && ack && !(tick && !clear && count == '1)) |=> !irq); // R7
    AST_WRAP_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack && tick && !clear && count == '1) |=> irq); // R8
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> !ovf_pulse); // R9

endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer
    import itmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       irq_ack,
    output logic       irq_req,
    output logic       wdt_tick,
    output logic       mode_wake,
    output logic       mode_rcwd,
    output logic       mode_wdog
);

    ctl_t             ctl;
    logic             pre_tick;
    logic [CNT_W-1:0] count;

    itmr_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl     (ctl)
    );

    itmr_prescaler #(.P_MIN_LOG2(MIN_LOG2), .P_SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl.clr),
        .rate    (ctl.rate),
        .tick    (pre_tick)
    );

    itmr_counter #(.P_CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clear     (ctl.clr),
        .tick      (pre_tick),
        .ack       (irq_ack),
        .count     (count),
        .irq       (irq_req),
        .ovf_pulse (wdt_tick)
    );

    assign rd_data   = count;
    assign mode_wake = ctl.wake_en;
    assign mode_rcwd = ctl.rc_wd_en;
    assign mode_wdog = ctl.wd_en;

    AST_CLEAR_ZEROES_COUNT: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (rd_data == 8'h00)); // R5

endmodule

// File: tb/sim_tick_interval_timer.sv
module sim_tick_interval_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic       wdt_tick;
    logic       mode_wake;
    logic       mode_rcwd;
    logic       mode_wdog;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    tick_interval_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req),
        .wdt_tick  (wdt_tick),
        .mode_wake (mode_wake),
        .mode_rcwd (mode_rcwd),
        .mode_wdog (mode_wdog)
    );

    // columns: ratio select, clocks after the clear took effect, expected count
    localparam int VEC [10][3] = '{
        '{0,   20, 2}, '{1,   40, 2}, '{2,  100, 3}, '{3,  200, 3},
        '{4,  300, 2}, '{5,  600, 2}, '{6, 1100, 2}, '{7, 2100, 2},
        '{0,    7, 0}, '{0,    8, 1}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // write a byte with bit 3 set; returns once the clear has taken effect
    task automatic write_clear(input int sel);
        wr_en   = 1'b1;
        wr_data = 8'h08 | 8'(sel);
        wait_clk(1);
        wr_en   = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_clk(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 count", rd_data, 0);
        check("R1 irq", irq_req, 0);
        check("R1 tick", wdt_tick, 0);
        check("R1 wake", mode_wake, 0);
        check("R1 rcwd", mode_rcwd, 0);
        check("R1 wdog", mode_wdog, 1);
        // R2 default divide by 1024
        wait_clk(1023);
        check("R2 count before period", rd_data, 0);
        wait_clk(1);
        check("R2 count after period", rd_data, 1);

        // R3 / R5 table walk
        for (int i = 0; i < 10; i++) begin
            write_clear(VEC[i][0]);
            check("R5 cleared", rd_data, 0);
            wait_clk(VEC[i][1]);
            check("R3 ratio count", rd_data, VEC[i][2]);
        end

        // R11 / R4: ratio change without clear keeps the count
        write_clear(0);
        wait_clk(40);
        check("R3 before change", rd_data, 5);
        wr_en   = 1'b1;
        wr_data = 8'h01;
        wait_clk(1);
        wr_en   = 1'b0;
        wait_clk(19);
        check("R11 R4 count kept, new ratio", rd_data, 6);

        // R10 mode levels
        wr_en   = 1'b1;
        wr_data = 8'h70;
        wait_clk(1);
        wr_en   = 1'b0;
        check("R10 wake", mode_wake, 1);
        check("R10 rcwd", mode_rcwd, 1);
        check("R10 wdog", mode_wdog, 1);
        wr_en   = 1'b1;
        wr_data = 8'h20;
        wait_clk(1);
        wr_en   = 1'b0;
        check("R10 wake off", mode_wake, 0);
        check("R10 rcwd on", mode_rcwd, 1);
        check("R10 wdog off", mode_wdog, 0);

        // R6 / R7 / R8 / R9 rollover
        write_clear(0);
        wait_clk(2047);
        check("R6 count at top", rd_data, 255);
        check("R6 irq before wrap", irq_req, 0);
        wait_clk(1);
        check("R6 count wrapped", rd_data, 0);
        check("R6 irq set", irq_req, 1);
        check("R9 tick high", wdt_tick, 1);
        wait_clk(1);
        check("R9 tick low", wdt_tick, 0);
        check("R7 irq held", irq_req, 1);
        irq_ack = 1'b1;
        wait_clk(1);
        irq_ack = 1'b0;
        check("R7 irq cleared", irq_req, 0);
        wait_clk(2045);
        check("R8 count at top", rd_data, 255);
        check("R8 irq low before", irq_req, 0);
        irq_ack = 1'b1;
        wait_clk(1);
        irq_ack = 1'b0;
        check("R8 irq kept on ack+wrap", irq_req, 1);
        check("R9 tick second wrap", wdt_tick, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule